// File: doc/BRIEF.md
# Clock-Monitor Interrupt Status Controller

This block collects events from the health monitors of a clock-synchronizer chip and turns them into one active-high interrupt request. The monitored signals are an external sync alarm, the lock flag of the secondary DPLL, a 4-bit index of the best validated input with a qualifier that says whether the index applies to the secondary path, and validity flags for two differential and two single-ended clock inputs. Every input is registered once. Each monitor then has its own rule for setting a sticky status bit. The alarm uses a rising edge. The lock flag uses any toggle. The index sets a bit when it reaches zero. Each validity flag uses any change.

Software reaches the block over a byte-wide bus with a synchronous write and a combinational read. It clears a status bit by writing 1 to that bit. An enable register masks the four validity-change bits before they reach the interrupt output. The three main status bits have no mask and always drive the output. These three bits come out of reset set, so the interrupt is asserted until software clears them.

Top module: `clkmon_irq_ctrl`

## Requirements
- R1: Status bit 7 at address 0x0F sets when the sync alarm input rises from 0 to 1. A fall of that input leaves the bit unchanged.
- R2: Status bit 6 at address 0x0F sets on every change of the lock input, in both directions.
- R3: Status bit 4 at address 0x0F sets when the 4-bit index changes from a nonzero value to 0000 while the secondary-path qualifier is 1. An index that stays at zero, or that reaches zero while the qualifier is 0, does not set it.
- R4: Status bits are sticky. Writing 1 to a bit position clears that bit, and writing 0 leaves it unchanged.
- R5: After reset, address 0x0F reads 0xD0 and addresses 0x0D and 0x10 read 0x00.
- R6: When a set event and a write-1 clear of the same bit land in the same cycle, the bit ends up set.
- R7: Any change of a validity flag sets a sticky bit at address 0x0D. Bits 5 and 4 are for differential inputs 2 and 1. Bits 3 and 2 are for single-ended inputs 2 and 1. These bits clear by writing 1.
- R8: The register at address 0x10 holds the enables, using the same bit positions as 0x0D. The irq output is the OR of bits 7, 6 and 4 of 0x0F together with each bit of 0x0D ANDed with its enable.
- R9: Reserved bits in all three registers read 0 and ignore writes. Addresses not in the map read 0x00.
- R10: A monitor event appears in the status two clock edges after the input changes. A write takes effect on the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from addr |
| sync_alarm | input | 1 | External sync alarm monitor |
| sec_lock | input | 1 | Secondary DPLL lock flag |
| best_idx | input | 4 | Highest-priority validated input index |
| idx_on_sec | input | 1 | 1 when best_idx applies to the secondary path |
| diff_valid | input | 2 | Validity of differential inputs 2 and 1 |
| se_valid | input | 2 | Validity of single-ended inputs 2 and 1 |
| irq | output | 1 | Interrupt request, active high |

## Verification
A change on a monitor input shows up in the status on the second rising edge after the change. The first edge registers the sample and the second edge sets the bit. A write takes effect on the one edge where wr_en is high. The bench drives every input on a falling edge and reads on a falling edge, so each check lands half a period after the edge that produced the result. The set-versus-clear case puts the write strobe on exactly the edge where the set fires. The enable sweep tries all sixteen enable values against each validity input and computes the expected irq from the enable bit alone.

// File: rtl/clkmon_irq_ctrl.sv
module clkmon_irq_ctrl #(
  parameter int AW = 8,
  parameter logic [AW-1:0] VC_ADDR = 8'h0D,
  parameter logic [AW-1:0] ST_ADDR = 8'h0F,
  parameter logic [AW-1:0] EN_ADDR = 8'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  input  logic          sync_alarm,
  input  logic          sec_lock,
  input  logic [3:0]    best_idx,
  input  logic          idx_on_sec,
  input  logic [1:0]    diff_valid,
  input  logic [1:0]    se_valid,
  output logic          irq
);

  logic        primed;
  logic        alm_q, alm_p, lck_q, lck_p, sec_q;
  logic [3:0]  idx_q, idx_p;
  logic [3:0]  val_q, val_p;
  logic        st_alm, st_lck, st_unq;
  logic [3:0]  st_vc, en;

  wire [3:0] val_in = {diff_valid, se_valid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      alm_q <= 1'b0; alm_p <= 1'b0;
      lck_q <= 1'b0; lck_p <= 1'b0;
      idx_q <= '0;   idx_p <= '0;
      val_q <= '0;   val_p <= '0;
      sec_q <= 1'b0;
    end else begin
      primed <= 1'b1;
      alm_q  <= sync_alarm;
      lck_q  <= sec_lock;
      idx_q  <= best_idx;
      val_q  <= val_in;
      sec_q  <= idx_on_sec;
      alm_p  <= primed ? alm_q : sync_alarm;
      lck_p  <= primed ? lck_q : sec_lock;
      idx_p  <= primed ? idx_q : best_idx;
      val_p  <= primed ? val_q : val_in;
    end
  end

  wire ev_alm = alm_q & ~alm_p;
  wire ev_lck = lck_q ^ lck_p;
  wire ev_unq = sec_q & (idx_q == 4'd0) & (idx_p != 4'd0);
  wire [3:0] ev_vc = val_q ^ val_p;

  wire wr_st = wr_en && addr == ST_ADDR;
  wire wr_vc = wr_en && addr == VC_ADDR;
  wire wr_en_reg = wr_en && addr == EN_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_alm <= 1'b1;
      st_lck <= 1'b1;
      st_unq <= 1'b1;
      st_vc  <= '0;
      en     <= '0;
    end else begin
      st_alm <= ev_alm | (st_alm & ~(wr_st & wr_data[7]));
      st_lck <= ev_lck | (st_lck & ~(wr_st & wr_data[6]));
      st_unq <= ev_unq | (st_unq & ~(wr_st & wr_data[4]));
      st_vc  <= ev_vc  | (st_vc & ~({4{wr_vc}} & wr_data[5:2]));
      if (wr_en_reg) en <= wr_data[5:2];
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (addr == ST_ADDR)      rd_data = {st_alm, st_lck, 1'b0, st_unq, 4'h0};
    else if (addr == VC_ADDR) rd_data = {2'b00, st_vc, 2'b00};
    else if (addr == EN_ADDR) rd_data = {2'b00, en, 2'b00};
  end

  assign irq = st_alm | st_lck | st_unq | |(st_vc & en);

  assert_alarm_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && alm_q && !alm_p) |=> st_alm);

  assert_lock_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && lck_q != lck_p) |=> st_lck);

  assert_unq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_unq) |-> $past(idx_q == 4'd0 && sec_q));

  assert_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_alm) |-> $past(wr_en && addr == ST_ADDR && wr_data[7]));

  assert_en_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == EN_ADDR) |=> $stable(en));

  always_comb
    if (rst_n && addr == ST_ADDR)
      assert_reserved_R9: assert (rd_data[5] == 1'b0 && rd_data[3:0] == 4'h0);

endmodule

// File: tb/clkmon_irq_ctrl_test.sv
module clkmon_irq_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0, wr_data = 0;
  logic wr_en = 0;
  logic [7:0] rd_data;
  logic sync_alarm = 0, sec_lock = 0, idx_on_sec = 0;
  logic [3:0] best_idx = 4'd3;
  logic [1:0] diff_valid = 0, se_valid = 0;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clkmon_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .sync_alarm(sync_alarm),
    .sec_lock(sec_lock), .best_idx(best_idx), .idx_on_sec(idx_on_sec),
    .diff_valid(diff_valid), .se_valid(se_valid), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string req, input logic [7:0] exp);
    addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(3);
    rd(8'h0F, "R5 status reset", 8'hD0);
    rd(8'h0D, "R5 validity reset", 8'h00);
    rd(8'h10, "R5 enable reset", 8'h00);
    chk("R8 irq after reset", {7'd0, irq}, 8'h01);

    wr(8'h0F, 8'h00);
    rd(8'h0F, "R4 write 0 keeps", 8'hD0);
    wr(8'h0F, 8'h40);
    rd(8'h0F, "R4 clear one bit", 8'h90);
    wr(8'h0F, 8'hFF);
    rd(8'h0F, "R4 R9 clear all", 8'h00);
    chk("R8 irq low when clear", {7'd0, irq}, 8'h00);

    sync_alarm = 1; cyc(1);
    rd(8'h0F, "R10 not yet after one edge", 8'h00);
    cyc(1);
    rd(8'h0F, "R1 rising alarm", 8'h80);
    chk("R8 irq from alarm", {7'd0, irq}, 8'h01);
    wr(8'h0F, 8'h80);
    sync_alarm = 0; cyc(3);
    rd(8'h0F, "R1 falling ignored", 8'h00);

    sec_lock = 1; cyc(2);
    rd(8'h0F, "R2 lock rise", 8'h40);
    wr(8'h0F, 8'h40);
    sec_lock = 0; cyc(2);
    rd(8'h0F, "R2 lock fall", 8'h40);
    wr(8'h0F, 8'h40);

    idx_on_sec = 0; best_idx = 0; cyc(3);
    rd(8'h0F, "R3 zero not on secondary", 8'h00);
    idx_on_sec = 1; cyc(3);
    rd(8'h0F, "R3 staying zero", 8'h00);
    best_idx = 4'd5; cyc(3);
    rd(8'h0F, "R3 nonzero", 8'h00);
    best_idx = 0; cyc(2);
    rd(8'h0F, "R3 reaches zero", 8'h10);
    wr(8'h0F, 8'h10);

    sync_alarm = 1; cyc(1);
    wr(8'h0F, 8'h80);
    rd(8'h0F, "R6 set beats clear", 8'h80);
    wr(8'h0F, 8'h80);
    sync_alarm = 0; cyc(2);
    rd(8'h0F, "R4 cleared", 8'h00);

    wr(8'h10, 8'hFF);
    rd(8'h10, "R9 enable reserved", 8'h3C);
    wr(8'h0D, 8'hFF);
    rd(8'h44, "R9 unmapped", 8'h00);

    for (int e = 0; e < 16; e++) begin
      wr(8'h10, 8'(e << 2));
      for (int i = 0; i < 4; i++) begin
        if (i >= 2) diff_valid[i-2] = ~diff_valid[i-2];
        else se_valid[i] = ~se_valid[i];
        cyc(2);
        rd(8'h0D, "R7 validity change", 8'(1 << (i + 2)));
        chk("R8 irq per enable", {7'd0, irq}, {7'd0, e[i]});
        wr(8'h0D, 8'h3C);
        rd(8'h0D, "R7 validity cleared", 8'h00);
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual 0 expected 1");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule